// File: doc/BRIEF.md
# Biphase-Level Line Encoder

This block merges a serial bit stream with its bit timing into one biphase-level line signal. Every bit becomes a cell with a level change in the middle, so a receiver can recover the timing from the line itself. Two outputs leave the block: the coded line and its exact inverse, for a differential driver.

The encoder runs on a clock at twice the baud rate. A one-cycle `bit_strobe` pulse stands for the rising edge of the bit clock. On the clock edge where the strobe is high, the encoder captures `data_in`. The two half-cells of that bit then fill the next two fast-clock cycles. If a strobe comes every second cycle, the cells follow one another with no gap. If no strobe comes, the line rests at its idle level. Both outputs come straight from flip-flops, so no combinational glitch reaches the line.

Top module: `manenc_top`

## Requirements
- R1: A captured 1 is sent as a high first half-cell followed by a low second half-cell (with the default `ONE_HIGH_FIRST = 1`).
- R2: A captured 0 is sent as a low first half-cell followed by a high second half-cell.
- R3: `data_in` is captured on the rising clock edge where `bit_strobe` is high. The first half-cell is on `tx` from that edge, and the second half-cell from the next edge. With strobes on every second edge, the cells run back to back.
- R4: `txb` is always the logical inverse of `tx`.
- R5: `rst` is synchronous and active high. On each edge where it is high, `tx` goes to the idle level, which is 0 by default, and `txb` goes to 1. After reset is released, the line stays idle until the first strobe.
- R6: A strobe on the edge that ends a first half-cell is ignored. `data_in` is not captured, the current cell finishes unchanged, and the line then returns to idle.
- R7: When the edge after a second half-cell has no strobe, `tx` returns to the idle level and stays there until the next strobe.
- R8: When two equal bits are sent back to back, `tx` changes level at the cell boundary as well as at mid-cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the baud rate |
| rst | input | 1 | Synchronous active-high reset |
| bit_strobe | input | 1 | One-cycle pulse marking the rising edge of the bit clock |
| data_in | input | 1 | Serial data bit, captured with the strobe |
| tx | output | 1 | Encoded line output |
| txb | output | 1 | Inverted line output |

## Verification
The bench builds the encoder with its default parameters: idle level low, and a one sent high-then-low. Under these values the idle resting level and each half-cell have known values, and the bench predicts them cycle by cycle. The stimulus covers:
- a long random stream with no gaps, which reaches runs of equal bits and the cell-boundary transitions they cause;
- isolated cells, which show the return to idle;
- strobes placed on the first half of a cell, which must be ignored;
- a reset applied in the middle of a cell.

// File: rtl/manenc_pkg.sv
package manenc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;
endpackage

// File: rtl/manenc_seq.sv
module manenc_seq
  import manenc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_strobe,
  input  logic   data_in,
  output phase_e phase_q,
  output phase_e phase_nxt,
  output logic   bit_q,
  output logic   bit_nxt,
  output logic   accept
);

  // A strobe is taken unless a first half-cell is on the line right now.
  always_comb begin
    accept    = bit_strobe && (phase_q != PH_FIRST);
    phase_nxt = PH_IDLE;
    bit_nxt   = bit_q;
    if (accept) begin
      phase_nxt = PH_FIRST;
      bit_nxt   = data_in;
    end else begin
      unique case (phase_q)
        PH_FIRST:  phase_nxt = PH_SECOND;
        PH_SECOND: phase_nxt = PH_IDLE;
        default:   phase_nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      bit_q   <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      bit_q   <= bit_nxt;
    end
  end

endmodule

// File: rtl/manenc_line.sv
module manenc_line
  import manenc_pkg::*;
#(
  parameter bit ONE_HIGH_FIRST = 1'b1,
  parameter bit IDLE_TX        = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase_nxt,
  input  logic   bit_nxt,
  output logic   tx,
  output logic   txb
);

  logic first_lvl;
  logic lvl;

  generate
    if (ONE_HIGH_FIRST) begin : g_one_high
      assign first_lvl = bit_nxt;
    end else begin : g_one_low
      assign first_lvl = ~bit_nxt;
    end
  endgenerate

  always_comb begin
    unique case (phase_nxt)
      PH_FIRST:  lvl = first_lvl;
      PH_SECOND: lvl = ~first_lvl;
      default:   lvl = IDLE_TX;
    endcase
  end

  // Both rails are registered on their own, so neither can glitch.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx  <= IDLE_TX;
      txb <= ~IDLE_TX;
    end else begin
      tx  <= lvl;
      txb <= ~lvl;
    end
  end

endmodule

// File: rtl/manenc_top.sv
module manenc_top
  import manenc_pkg::*;
#(
  parameter bit ONE_HIGH_FIRST = 1'b1,
  parameter bit IDLE_TX        = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_strobe,
  input  logic data_in,
  output logic tx,
  output logic txb
);

  phase_e phase_q;
  phase_e phase_nxt;
  logic   bit_q;
  logic   bit_nxt;
  logic   accept;

  manenc_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .bit_strobe (bit_strobe),
    .data_in    (data_in),
    .phase_q    (phase_q),
    .phase_nxt  (phase_nxt),
    .bit_q      (bit_q),
    .bit_nxt    (bit_nxt),
    .accept     (accept)
  );

  manenc_line #(
    .ONE_HIGH_FIRST (ONE_HIGH_FIRST),
    .IDLE_TX        (IDLE_TX)
  ) u_line (
    .clk       (clk),
    .rst       (rst),
    .phase_nxt (phase_nxt),
    .bit_nxt   (bit_nxt),
    .tx        (tx),
    .txb       (txb)
  );

endmodule

// File: rtl/manenc_chk.sv
module manenc_chk
  import manenc_pkg::*;
#(
  parameter bit ONE_HIGH_FIRST = 1'b1,
  parameter bit IDLE_TX        = 1'b0
) (
  input logic   clk,
  input logic   rst,
  input logic   bit_strobe,
  input logic   data_in,
  input logic   tx,
  input logic   txb,
  input phase_e phase_q,
  input logic   accept
);

  // R3: the first half-cell follows the captured bit.
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    accept |=> (tx == (ONE_HIGH_FIRST ? $past(data_in) : !$past(data_in))));

  // R1 and R2: every cell changes level at mid-cell.
  a_r1_midcell: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FIRST) |=> (tx == !$past(tx)));

  a_r4_complement: assert property (@(posedge clk) disable iff (rst)
    txb == !tx);

  a_r5_reset_idle: assert property (@(posedge clk)
    rst |=> (tx == IDLE_TX && txb == !IDLE_TX));

  a_r6_ignore_strobe: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FIRST && bit_strobe) |=> (phase_q == PH_SECOND));

  a_r7_return_idle: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SECOND && !bit_strobe) |=> (tx == IDLE_TX));

endmodule

bind manenc_top manenc_chk #(
  .ONE_HIGH_FIRST (ONE_HIGH_FIRST),
  .IDLE_TX        (IDLE_TX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_strobe (bit_strobe),
  .data_in    (data_in),
  .tx         (tx),
  .txb        (txb),
  .phase_q    (phase_q),
  .accept     (accept)
);

// File: tb/tb_manenc_top.sv
`timescale 1ns/1ps
module tb_manenc_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_strobe = 1'b0;
  logic data_in = 1'b0;
  logic tx;
  logic txb;

  always #2.5 clk = ~clk;

  manenc_top dut (
    .clk        (clk),
    .rst        (rst),
    .bit_strobe (bit_strobe),
    .data_in    (data_in),
    .tx         (tx),
    .txb        (txb)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  logic  exp_q[$];
  string tag_q[$];
  bit    mon_on  = 1'b0;
  bit    done    = 1'b0;

  // Reference state: 0 idle, 1 first half on line, 2 second half on line.
  int   m_ph  = 0;
  logic m_bit = 1'b0;

  // Driver: applies one cycle of stimulus at the falling edge and queues
  // the tx level expected after the next rising edge.
  task automatic drive(input logic r, input logic s, input logic d);
    logic  e;
    string t;
    @(negedge clk);
    rst = r; bit_strobe = s; data_in = d;
    if (r) begin
      e = 1'b0; t = "R5"; m_ph = 0;
    end else if (s && m_ph != 1) begin
      if (m_ph == 2 && d == m_bit) t = "R8";
      else t = d ? "R1" : "R2";
      m_ph = 1; m_bit = d; e = d;
    end else if (m_ph == 1) begin
      t = s ? "R6" : (m_bit ? "R1" : "R2");
      m_ph = 2; e = ~m_bit;
    end else if (m_ph == 2) begin
      t = "R7"; m_ph = 0; e = 1'b0;
    end else begin
      t = "R7"; e = 1'b0;
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Monitor: samples well after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on && exp_q.size() > 0) begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if (tx !== e) begin
          n_fail++;
          $display("FAIL %s (R3 timing): tx=%b expected %b at %0t", t, tx, e, $time);
        end
        n_tests++;
        if (txb !== ~e) begin
          n_fail++;
          $display("FAIL R4: txb=%b expected %b at %0t", txb, ~e, $time);
        end
      end
    end
  end

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: expired, expected run to finish");
    finish_run();
  end

  initial begin
    mon_on = 1'b1;
    // R5: reset, then idle with no strobes.
    repeat (3) drive(1'b1, 1'b0, 1'b0);
    repeat (3) drive(1'b0, 1'b0, 1'b1);
    // R1, R2, R7: isolated cells.
    drive(1'b0, 1'b1, 1'b1); drive(1'b0, 1'b0, 1'b0); drive(1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0); drive(1'b0, 1'b0, 1'b1); drive(1'b0, 1'b0, 1'b1);
    // R8: back-to-back equal bits.
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 1'b1, 1'b1); drive(1'b0, 1'b0, 1'b0);
    end
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 1'b1, 1'b0); drive(1'b0, 1'b0, 1'b1);
    end
    drive(1'b0, 1'b0, 1'b0);
    // R6: strobe placed on the first half-cell is ignored.
    drive(1'b0, 1'b1, 1'b1); drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0); drive(1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0); drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b1); drive(1'b0, 1'b0, 1'b1);
    // R3: continuous random stream.
    for (int i = 0; i < 300; i++) begin
      drive(1'b0, 1'b1, 1'($urandom_range(0, 1)));
      drive(1'b0, 1'b0, 1'($urandom_range(0, 1)));
    end
    // Random strobe pattern with gaps and stray strobes.
    for (int i = 0; i < 400; i++) begin
      drive(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    // R5: reset in the middle of a cell.
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0); drive(1'b0, 1'b0, 1'b0); drive(1'b0, 1'b0, 1'b0);
    wait (exp_q.size() == 0);
    @(posedge clk); #3;
    done = 1'b1;
    finish_run();
  end

endmodule